// File: doc/BRIEF.md
# GPIO Output and Direction Register Block with Atomic Bit Aliases

This block holds the drive level and the direction of two banks of general-purpose pins: a main bank of 30 pins and an auxiliary bank of 6 pins. Software reaches it over a simple register bus with a word address, a write strobe, write data and combinational read data. Each of the four control registers has four addresses. The first loads the whole register. The other three change only the bits written as 1: they set them, clear them or invert them. Several agents can therefore change separate pins without a read-modify-write sequence that could race.

Pin levels coming back from the pads pass through a two-stage synchronizer. They can then be read from two read-only registers, with each pin in the same bit position it has in the output registers. Pad multiplexing, pull resistors and interrupts belong to other blocks.

Word address map: 0 main input, 1 auxiliary input, 2..5 main output (load, set, clear, invert), 6..9 main direction, 10..13 auxiliary output, 14..17 auxiliary direction. Every other address is unused.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, both output-level registers and both direction registers hold 0, so every pin is an input and would drive low.
- R2: A write to a load address (2, 6, 10, 14) replaces the register. The register reads back at the same address and appears on the matching pin port on the next clock. In a direction register, 1 means output and 0 means input. In an output register, 1 means high.
- R3: A write to a set address (3, 7, 11, 15) gives the new register value as old OR write data.
- R4: A write to a clear address (4, 8, 12, 16) gives the new register value as old AND NOT write data.
- R5: A write to an invert address (5, 9, 13, 17) gives the new register value as old XOR write data.
- R6: Reads from the set, clear and invert addresses return 0.
- R7: Address 0 returns the synchronized main pin levels in bits [29:0]. Address 1 returns the synchronized auxiliary levels in bits [5:0]. Writes to either address change no register and no output.
- R8: A change on an input pin becomes visible in the read data after exactly two rising clock edges.
- R9: Write-data bits at or above the bank width (30 for main, 6 for auxiliary) are ignored, and they read back as 0.
- R10: A write aimed at one register leaves the other three registers unchanged.
- R11: Addresses 18 and above read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| main_pin_in | input | 30 | Main bank pad levels (asynchronous) |
| main_pin_out | output | 30 | Main bank drive levels |
| main_pin_oe | output | 30 | Main bank direction, 1 = output |
| aux_pin_in | input | 6 | Auxiliary bank pad levels (asynchronous) |
| aux_pin_out | output | 6 | Auxiliary bank drive levels |
| aux_pin_oe | output | 6 | Auxiliary bank direction, 1 = output |

## Verification
Some properties are checked on every cycle. Each set, clear and invert update leaves the register in the relation required with its previous value and the write data, and a register not written holds its value. The synchronizer output equals its input from two edges earlier. Alias and unused addresses read zero, and writes to read-only or unused addresses leave every output unchanged. Other behaviour needs the bench's directed scenarios: specific value sequences through each alias on both banks, the exact sample at which a pin change shows up in read data, the discarding of upper write bits, and the independence of the four registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int MAIN_PINS = 30;
    localparam int AUX_PINS  = 6;
    localparam int ALIASES   = 4;

    // Operation chosen by the offset inside a register's four-address window
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_FLIP = 2'd3
    } wr_op_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MAIN_IN,
        TGT_AUX_IN,
        TGT_MAIN_OUT,
        TGT_MAIN_OE,
        TGT_AUX_OUT,
        TGT_AUX_OE
    } tgt_e;

    typedef struct packed {
        tgt_e   tgt;
        wr_op_e op;
    } decode_t;

    localparam logic [ADDR_W-1:0] A_MAIN_IN  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_AUX_IN   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MAIN_OUT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MAIN_OE  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_AUX_OUT  = ADDR_W'(10);
    localparam logic [ADDR_W-1:0] A_AUX_OE   = ADDR_W'(14);

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] offs;
        offs = a - base;
        return (a >= base) && (offs < ADDR_W'(ALIASES));
    endfunction

    function automatic wr_op_e op_of(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] offs;
        offs = a - base;
        return wr_op_e'(offs[1:0]);
    endfunction

    function automatic decode_t decode(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.tgt = TGT_NONE;
        d.op  = OP_LOAD;
        if (a == A_MAIN_IN) begin
            d.tgt = TGT_MAIN_IN;
        end else if (a == A_AUX_IN) begin
            d.tgt = TGT_AUX_IN;
        end else if (in_window(a, A_MAIN_OUT)) begin
            d.tgt = TGT_MAIN_OUT;
            d.op  = op_of(a, A_MAIN_OUT);
        end else if (in_window(a, A_MAIN_OE)) begin
            d.tgt = TGT_MAIN_OE;
            d.op  = op_of(a, A_MAIN_OE);
        end else if (in_window(a, A_AUX_OUT)) begin
            d.tgt = TGT_AUX_OUT;
            d.op  = op_of(a, A_AUX_OUT);
        end else if (in_window(a, A_AUX_OE)) begin
            d.tgt = TGT_AUX_OE;
            d.op  = op_of(a, A_AUX_OE);
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [1:0]       age;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Cycles since reset, saturating, used only to gate the latency check
    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_two_edge_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  wr_op_e           op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = wdata;
            OP_SET:  nxt = q | wdata;
            OP_CLR:  nxt = q & ~wdata;
            OP_FLIP: nxt = q ^ wdata;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= nxt;
    end

    p_set_bits_high_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_SET) |=>
            ((q & $past(wdata)) == $past(wdata)) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    p_clr_bits_low_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_CLR) |=>
            ((q & $past(wdata)) == '0) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    p_flip_changes_written_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_FLIP) |=> ((q ^ $past(q)) == $past(wdata)));

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_pkg::*;
#(
    parameter int MAIN_W = MAIN_PINS,
    parameter int AUX_W  = AUX_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [MAIN_W-1:0] main_pin_in,
    output logic [MAIN_W-1:0] main_pin_out,
    output logic [MAIN_W-1:0] main_pin_oe,
    input  logic [AUX_W-1:0]  aux_pin_in,
    output logic [AUX_W-1:0]  aux_pin_out,
    output logic [AUX_W-1:0]  aux_pin_oe
);
    decode_t dec;
    assign dec = decode(bus_addr);

    logic [MAIN_W-1:0] main_sync;
    logic [AUX_W-1:0]  aux_sync;

    gpio_sync2 #(.WIDTH(MAIN_W)) u_main_sync (
        .clk(clk), .rst(rst), .d(main_pin_in), .q(main_sync));
    gpio_sync2 #(.WIDTH(AUX_W)) u_aux_sync (
        .clk(clk), .rst(rst), .d(aux_pin_in), .q(aux_sync));

    gpio_alias_reg #(.WIDTH(MAIN_W)) u_main_out (
        .clk(clk), .rst(rst),
        .wr_en(bus_we && dec.tgt == TGT_MAIN_OUT), .op(dec.op),
        .wdata(bus_wdata[MAIN_W-1:0]), .q(main_pin_out));
    gpio_alias_reg #(.WIDTH(MAIN_W)) u_main_oe (
        .clk(clk), .rst(rst),
        .wr_en(bus_we && dec.tgt == TGT_MAIN_OE), .op(dec.op),
        .wdata(bus_wdata[MAIN_W-1:0]), .q(main_pin_oe));
    gpio_alias_reg #(.WIDTH(AUX_W)) u_aux_out (
        .clk(clk), .rst(rst),
        .wr_en(bus_we && dec.tgt == TGT_AUX_OUT), .op(dec.op),
        .wdata(bus_wdata[AUX_W-1:0]), .q(aux_pin_out));
    gpio_alias_reg #(.WIDTH(AUX_W)) u_aux_oe (
        .clk(clk), .rst(rst),
        .wr_en(bus_we && dec.tgt == TGT_AUX_OE), .op(dec.op),
        .wdata(bus_wdata[AUX_W-1:0]), .q(aux_pin_oe));

    // Only the load address of a register returns its value
    logic load_slot;
    assign load_slot = (dec.op == OP_LOAD);

    always_comb begin
        bus_rdata = '0;
        unique case (dec.tgt)
            TGT_MAIN_IN:  bus_rdata = DATA_W'(main_sync);
            TGT_AUX_IN:   bus_rdata = DATA_W'(aux_sync);
            TGT_MAIN_OUT: if (load_slot) bus_rdata = DATA_W'(main_pin_out);
            TGT_MAIN_OE:  if (load_slot) bus_rdata = DATA_W'(main_pin_oe);
            TGT_AUX_OUT:  if (load_slot) bus_rdata = DATA_W'(aux_pin_out);
            TGT_AUX_OE:   if (load_slot) bus_rdata = DATA_W'(aux_pin_oe);
            default:      bus_rdata = '0;
        endcase
    end

    p_alias_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= A_MAIN_OUT && bus_addr < ADDR_W'(18) && bus_addr != A_MAIN_OUT
         && bus_addr != A_MAIN_OE && bus_addr != A_AUX_OUT && bus_addr != A_AUX_OE)
        |-> (bus_rdata == '0));

    p_ro_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr <= A_AUX_IN) |=>
            ($stable(main_pin_out) && $stable(main_pin_oe) && $stable(aux_pin_out) && $stable(aux_pin_oe)));

    p_aux_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_AUX_OUT || bus_addr == A_AUX_OE || bus_addr == A_AUX_IN)
        |-> (bus_rdata[DATA_W-1:AUX_W] == '0));

    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(18)) |-> (bus_rdata == '0));

    p_unmapped_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr >= ADDR_W'(18)) |=>
            ($stable(main_pin_out) && $stable(main_pin_oe) && $stable(aux_pin_out) && $stable(aux_pin_oe)));

endmodule

// File: tb/gpio_bank_regs_tb.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [29:0] main_pin_in = '0;
    logic [29:0] main_pin_out, main_pin_oe;
    logic [5:0]  aux_pin_in = '0;
    logic [5:0]  aux_pin_out, aux_pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected register contents, kept by the bench
    logic [29:0] e_mo = '0, e_moe = '0;
    logic [5:0]  e_ao = '0, e_aoe = '0;

    always #2.5 clk = ~clk;

    gpio_bank_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .main_pin_in(main_pin_in), .main_pin_out(main_pin_out), .main_pin_oe(main_pin_oe),
        .aux_pin_in(aux_pin_in), .aux_pin_out(aux_pin_out), .aux_pin_oe(aux_pin_oe));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk_all(input string req);
        logic [31:0] v;
        chk(req, 32'(main_pin_out), 32'(e_mo));
        chk(req, 32'(main_pin_oe),  32'(e_moe));
        chk(req, 32'(aux_pin_out),  32'(e_ao));
        chk(req, 32'(aux_pin_oe),   32'(e_aoe));
        rd(5'd2, v);  chk(req, v, 32'(e_mo));
        rd(5'd6, v);  chk(req, v, 32'(e_moe));
        rd(5'd10, v); chk(req, v, 32'(e_ao));
        rd(5'd14, v); chk(req, v, 32'(e_aoe));
    endtask

    task automatic t_reset();
        chk_all("R1 reset state");
    endtask

    task automatic t_load();
        wr(5'd2, 32'hFFFF_FFFF); e_mo = 30'h3FFF_FFFF;
        chk_all("R2/R9 load main out, upper bits dropped");
        wr(5'd6, 32'hD234_5678); e_moe = 30'h1234_5678;
        chk_all("R2/R9/R10 load main oe");
        wr(5'd10, 32'hFFFF_FFEA); e_ao = 6'h2A;
        chk_all("R2/R9 load aux out");
        wr(5'd14, 32'h0000_0055); e_aoe = 6'h15;
        chk_all("R2/R10 load aux oe");
    endtask

    task automatic t_set();
        wr(5'd2, 32'h0000_0F0F); e_mo = 30'h0F0F;
        wr(5'd3, 32'hC000_00F0); e_mo = 30'h0FFF;
        chk_all("R3/R9 set main out");
        wr(5'd15, 32'h0000_002A); e_aoe = 6'h3F;
        chk_all("R3 set aux oe");
    endtask

    task automatic t_clr();
        wr(5'd4, 32'h0000_0F00); e_mo = 30'h00FF;
        chk_all("R4 clear main out");
        wr(5'd8, 32'hFFFF_0000); e_moe = 30'h0000_5678;
        chk_all("R4 clear main oe");
        wr(5'd12, 32'h0000_0003); e_ao = 6'h28;
        chk_all("R4 clear aux out");
    endtask

    task automatic t_flip();
        wr(5'd5, 32'h0000_0FF0); e_mo = 30'h0F0F;
        chk_all("R5 invert main out");
        wr(5'd5, 32'h0000_0FF0); e_mo = 30'h00FF;
        chk_all("R5 invert twice restores");
        wr(5'd9, 32'h2000_0001); e_moe = 30'h2000_5679;
        chk_all("R5 invert main oe");
        wr(5'd17, 32'hFFFF_FFFF); e_aoe = 6'h00;
        chk_all("R5/R9 invert aux oe");
        wr(5'd13, 32'h0000_0011); e_ao = 6'h39;
        chk_all("R5 invert aux out");
    endtask

    task automatic t_alias_reads();
        logic [31:0] v;
        for (int a = 2; a < 18; a++) begin
            if ((a - 2) % 4 != 0) begin
                rd(5'(a), v);
                chk("R6 alias reads zero", v, 32'h0);
            end
        end
    endtask

    task automatic t_inputs();
        logic [31:0] v;
        // pins change at a negedge; two rising edges must pass before read shows it
        @(negedge clk);
        main_pin_in = 30'h2AAA_5555; aux_pin_in = 6'h2D; bus_addr = 5'd0;
        #1 chk("R8 no change before first edge", bus_rdata, 32'h0);
        @(negedge clk); #1 chk("R8 no change after one edge", bus_rdata, 32'h0);
        @(negedge clk); #1 chk("R8/R7 main visible after two edges", bus_rdata, 32'h2AAA_5555);
        rd(5'd1, v); chk("R7 aux input value", v, 32'h2D);
        wr(5'd0, 32'h1234_5678);
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd0, v); chk("R7 write to main input ignored", v, 32'h2AAA_5555);
        rd(5'd1, v); chk("R7 write to aux input ignored", v, 32'h2D);
        chk_all("R7 input write leaves outputs");
        main_pin_in = 30'h3FFF_FFFF;
        repeat (2) @(negedge clk);
        rd(5'd0, v); chk("R7/R9 main input all high", v, 32'h3FFF_FFFF);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(5'd18, 32'hFFFF_FFFF);
        wr(5'd31, 32'hFFFF_FFFF);
        chk_all("R11 unmapped writes ignored");
        rd(5'd18, v); chk("R11 unmapped reads zero", v, 32'h0);
        rd(5'd31, v); chk("R11 top address reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_set();
        t_clr();
        t_flip();
        t_alias_reads();
        t_inputs();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule